// File: doc/BRIEF.md
# Tear-Free Split-Read 64-bit System Timer

A free-running system timer whose count is wider than the 32-bit register interface that reads it. Software reads the count as two words. Reading the low word stores the upper half of the same count value in a dedicated snapshot register. A following read of the snapshot register returns that stored half, not the live one. The pair of reads therefore describes one instant even while the counter keeps advancing. The snapshot is shared by all readers. A low-word read by one agent refreshes it for everyone, so an interleaved access can still produce a value exactly 2^32 too high. Software defends against this by reading twice and keeping the smaller result.

The count advances on cycles where the tick input is high and the channel is running. A compare register can send the count back to zero and sets a sticky match flag. A mode bit lets the count run straight past the compare value instead. Software may load either count half directly, for example to clear it before starting. A parameter selects a narrow variant with a 32-bit counter, which software reads at the high-word address.

Top module: `split_read_timer`

## Requirements
- R1: After reset the count, the snapshot, the control word, the compare value, the run bit and the match flag are all zero, so every mapped register reads 0.
- R2: On each cycle with `tick_i` high and the channel running, the count increases by one. A carry out of bit 31 reaches the upper word in that same cycle. With the channel stopped, ticks leave the count unchanged.
- R3: A read of COUNT_LO (address 3) copies the upper count half of that cycle into SNAP (address 5). SNAP keeps this value until the next COUNT_LO read, whatever the live upper word does. Every COUNT_LO read, from any agent, overwrites SNAP.
- R4: Writing COUNT_LO or COUNT_HI (address 4) replaces that half of the count. The count does not advance in a cycle that carries such a write.
- R5: Writing a word with bit 15 set to RUN_SET (address 6) starts the channel, and writing one with bit 15 set to RUN_CLR (address 7) stops it. Words with bit 15 clear have no effect on either register. RUN_STAT (address 8) shows the run bit at bit 15. RUN_SET and RUN_CLR read 0.
- R6: With CTRL (address 0) bit 15 set, the count runs past the compare value without returning to zero.
- R7: With CTRL bit 15 clear, an advancing tick while the count equals the compare value (CMP_LO address 1, CMP_HI address 2) sets the count to zero.
- R8: An advancing tick while the count equals the compare value sets the MATCH flag (address 9, bit 0) in either mode. The flag stays set until a write with bit 0 set clears it. Writing 0 to bit 0 has no effect.
- R9: CTRL bits 7:6 store and read back what was written but change nothing. All other CTRL bits except bit 15 read as 0.
- R10: With `WIDE` = 0 the counter is 32 bits and is read and written at COUNT_HI, wrapping from 0xFFFFFFFF to 0. COUNT_LO, SNAP and CMP_HI read 0.
- R11: `rd_data_o` is 0 when `rd_en_i` is low and for addresses 10 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-enable pulse |
| addr_i | input | 4 | Register word address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe; a COUNT_LO read refreshes SNAP |
| rd_data_o | output | 32 | Read data, combinational from current state |

## Verification
The hardest situation to produce is the torn read. It needs the low word to be read just before a carry into the upper half, a tick to cross the 32-bit boundary, and a second COUNT_LO read before the first reader fetches SNAP. The bench loads the count to 0x3_FFFFFFFF with direct writes while the channel runs, with no ticks. It reads the low word, gives one tick, issues the intruding low read and then fetches SNAP, and checks that the combined value is exactly 2^32 above the true one. The compare reset and the legacy wrap are reached the same way, by loading counts next to the boundary rather than ticking there.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int AW       = 4;
    localparam int DW       = 32;
    localparam int RUN_BIT  = 15;
    localparam int MODE_BIT = 15;

    localparam logic [AW-1:0] A_CTRL   = 4'd0;
    localparam logic [AW-1:0] A_CMPL   = 4'd1;
    localparam logic [AW-1:0] A_CMPH   = 4'd2;
    localparam logic [AW-1:0] A_CNTL   = 4'd3;
    localparam logic [AW-1:0] A_CNTH   = 4'd4;
    localparam logic [AW-1:0] A_SNAP   = 4'd5;
    localparam logic [AW-1:0] A_RUNSET = 4'd6;
    localparam logic [AW-1:0] A_RUNCLR = 4'd7;
    localparam logic [AW-1:0] A_RUNST  = 4'd8;
    localparam logic [AW-1:0] A_MATCH  = 4'd9;

    // writable CTRL bits: mode bit 15 and inert field 7:6
    localparam logic [DW-1:0] CTRL_MASK = 32'h0000_80C0;
endpackage

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             free_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             ld_lo_i,
    input  logic             ld_hi_i,
    input  logic [31:0]      ld_data_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] load_val;

    generate
        if (CNT_W > 32) begin : g_split
            assign load_val = {ld_hi_i ? ld_data_i : cnt_q[CNT_W-1:32],
                               ld_lo_i ? ld_data_i : cnt_q[31:0]};
        end else begin : g_single
            assign load_val = ld_data_i;
        end
    endgenerate

    always_comb begin
        cnt_d = cnt_q;
        hit_o = 1'b0;
        if (ld_lo_i || ld_hi_i) begin
            cnt_d = load_val;
        end else if (run_i) begin
            hit_o = (cnt_q == cmp_i);
            cnt_d = (hit_o && !free_i) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux
    import tmr_pkg::*;
#(
    parameter bit WIDE  = 1'b1,
    parameter int CNT_W = 64
) (
    input  logic             rd_en_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    ctrl_i,
    input  logic [63:0]      cmp_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [DW-1:0]    snap_i,
    input  logic             run_i,
    input  logic             match_i,
    output logic [DW-1:0]    rd_data_o
);
    logic [DW-1:0] cnt_lo, cnt_hi;

    generate
        if (WIDE) begin : g_wide
            assign cnt_lo = cnt_i[31:0];
            assign cnt_hi = cnt_i[CNT_W-1:32];
        end else begin : g_narrow
            assign cnt_lo = '0;
            assign cnt_hi = cnt_i;
        end
    endgenerate

    always_comb begin
        rd_data_o = '0;
        if (rd_en_i) begin
            case (addr_i)
                A_CTRL:  rd_data_o = ctrl_i;
                A_CMPL:  rd_data_o = cmp_i[31:0];
                A_CMPH:  rd_data_o = cmp_i[63:32];
                A_CNTL:  rd_data_o = cnt_lo;
                A_CNTH:  rd_data_o = cnt_hi;
                A_SNAP:  rd_data_o = snap_i;
                A_RUNST: rd_data_o[RUN_BIT] = run_i;
                A_MATCH: rd_data_o[0] = match_i;
                default: rd_data_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/split_read_timer.sv
module split_read_timer
    import tmr_pkg::*;
#(
    parameter bit WIDE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          rd_en_i,
    output logic [DW-1:0] rd_data_o
);
    localparam int CNT_W = WIDE ? 64 : 32;

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [63:0]   cmp;
        logic [DW-1:0] snap;
        logic          run;
        logic          match;
    } regs_t;

    regs_t st_d, st_q;

    logic [CNT_W-1:0] cnt;
    logic [63:0]      cnt64;
    logic [CNT_W-1:0] cmp_use;
    logic             hit;
    logic             ld_lo, ld_hi;

    assign cnt64   = 64'(cnt);
    assign cmp_use = st_q.cmp[CNT_W-1:0];
    assign ld_lo   = WIDE && wr_en_i && (addr_i == A_CNTL);
    assign ld_hi   = wr_en_i && (addr_i == A_CNTH);

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (st_q.run && tick_i),
        .free_i    (st_q.ctrl[MODE_BIT]),
        .cmp_i     (cmp_use),
        .ld_lo_i   (ld_lo),
        .ld_hi_i   (ld_hi),
        .ld_data_i (wr_data_i),
        .cnt_o     (cnt),
        .hit_o     (hit)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            case (addr_i)
                A_CTRL:   st_d.ctrl = wr_data_i & CTRL_MASK;
                A_CMPL:   st_d.cmp[31:0] = wr_data_i;
                A_CMPH:   if (WIDE) st_d.cmp[63:32] = wr_data_i;
                A_RUNSET: if (wr_data_i[RUN_BIT]) st_d.run = 1'b1;
                A_RUNCLR: if (wr_data_i[RUN_BIT]) st_d.run = 1'b0;
                A_MATCH:  if (wr_data_i[0]) st_d.match = 1'b0;
                default:  ;
            endcase
        end
        // snapshot of the upper half taken with every low-word read
        if (WIDE && rd_en_i && (addr_i == A_CNTL)) begin
            st_d.snap = cnt64[63:32];
        end
        // a new match outranks a clear in the same cycle
        if (hit) begin
            st_d.match = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tmr_read_mux #(.WIDE(WIDE), .CNT_W(CNT_W)) u_rmux (
        .rd_en_i   (rd_en_i),
        .addr_i    (addr_i),
        .ctrl_i    (st_q.ctrl),
        .cmp_i     (st_q.cmp),
        .cnt_i     (cnt),
        .snap_i    (st_q.snap),
        .run_i     (st_q.run),
        .match_i   (st_q.match),
        .rd_data_o (rd_data_o)
    );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter bit WIDE = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_i,
    input logic [AW-1:0] addr_i,
    input logic          wr_en_i,
    input logic [DW-1:0] wr_data_i,
    input logic          rd_en_i,
    input logic [DW-1:0] rd_data_o,
    input logic [63:0]   cnt64,
    input logic [63:0]   cmp64,
    input logic [DW-1:0] snap,
    input logic          run_q,
    input logic          match_q,
    input logic          mode_q
);
    logic cnt_wr, adv;
    assign cnt_wr = wr_en_i && (addr_i == A_CNTL || addr_i == A_CNTH);
    assign adv    = run_q && tick_i && !cnt_wr;

    // R3
    snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (WIDE && rd_en_i && addr_i == A_CNTL) |=> (snap == $past(cnt64[63:32])));

    // R3
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_i && addr_i == A_CNTL) |=> $stable(snap));

    // R5
    run_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_RUNSET && wr_data_i[RUN_BIT]) |=> run_q);

    // R5
    run_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_RUNCLR && wr_data_i[RUN_BIT]) |=> !run_q);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && !(run_q && tick_i)) |=> $stable(cnt64));

    // R7
    cmp_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !mode_q && cnt64 == cmp64) |=> (cnt64 == 64'd0));

    // R8
    match_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt64 == cmp64) |=> match_q);

    // R11
    quiet_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en_i || addr_i > A_MATCH) |-> (rd_data_o == '0));
endmodule

bind split_read_timer tmr_chk #(.WIDE(WIDE)) u_tmr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .cnt64     (cnt64),
    .cmp64     (64'(cmp_use)),
    .snap      (st_q.snap),
    .run_q     (st_q.run),
    .match_q   (st_q.match),
    .mode_q    (st_q.ctrl[15])
);

// File: tb/split_read_timer_bench.sv
module split_read_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [3:0]  addr_i = '0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic        rd_en_i = 1'b0;
    logic [31:0] rd_wide, rd_leg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          leg;
        logic [3:0]  addr;
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    split_read_timer #(.WIDE(1'b1)) u_split_read_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
        .rd_data_o(rd_wide));

    split_read_timer #(.WIDE(1'b0)) u_split_read_timer_legacy (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
        .rd_data_o(rd_leg));

    // monitor: compare each read against the oldest expected item
    always @(negedge clk) begin
        if (rd_en_i) begin
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read addr %0d got %h exp none", addr_i, rd_wide);
            end else begin
                exp_t it;
                logic [31:0] got;
                it = sb_q.pop_front();
                got = it.leg ? rd_leg : rd_wide;
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr %0d got %h exp %h", it.tag, it.addr, got, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
        @(posedge clk); #1;
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input bit leg, input logic [3:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        it.leg = leg; it.addr = a; it.exp = e; it.tag = tag;
        @(posedge clk); #1;
        sb_q.push_back(it);
        addr_i = a; rd_en_i = 1'b1;
        @(posedge clk); #1;
        rd_en_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(posedge clk); #1;
        tick_i = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick_i = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got hung exp finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(0, 4'd0, 32'h0, "R1 ctrl");
        rd(0, 4'd3, 32'h0, "R1 count_lo");
        rd(0, 4'd4, 32'h0, "R1 count_hi");
        rd(0, 4'd5, 32'h0, "R1 snap");
        rd(0, 4'd8, 32'h0, "R1 run_stat");
        rd(0, 4'd9, 32'h0, "R1 match");

        // R5 zero bit 15 is ignored, then start
        wr(4'd6, 32'h0000_7FFF);
        rd(0, 4'd8, 32'h0, "R5 set without bit15");
        wr(4'd6, 32'h0000_8000);
        rd(0, 4'd8, 32'h0000_8000, "R5 run_stat after set");
        rd(0, 4'd6, 32'h0, "R5 run_set reads 0");

        // R2 counting with compare far away
        wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd2, 32'hFFFF_FFFF);
        ticks(10);
        rd(0, 4'd3, 32'd10, "R2 ten ticks");
        wr(4'd7, 32'h0000_7FFF);
        rd(0, 4'd8, 32'h0000_8000, "R5 clr without bit15");
        wr(4'd7, 32'h0000_8000);
        rd(0, 4'd8, 32'h0, "R5 run_stat after clr");
        ticks(5);
        rd(0, 4'd3, 32'd10, "R2 stopped ignores ticks");

        // R2 R4 carry into upper word
        wr(4'd3, 32'hFFFF_FFFE);
        wr(4'd4, 32'd5);
        wr(4'd6, 32'h0000_8000);
        ticks(1);
        rd(0, 4'd3, 32'hFFFF_FFFF, "R4 loaded low plus one");
        rd(0, 4'd5, 32'd5, "R3 snap before carry");
        ticks(1);
        rd(0, 4'd3, 32'h0, "R2 low wraps");
        rd(0, 4'd4, 32'd6, "R2 carry same cycle");
        rd(0, 4'd5, 32'd6, "R3 snap after carry");

        // R3 snapshot is not the live word, and a new low read refreshes it
        wr(4'd4, 32'd9);
        rd(0, 4'd5, 32'd6, "R3 snap keeps captured");
        rd(0, 4'd4, 32'd9, "R4 count_hi written");
        rd(0, 4'd3, 32'h0, "R3 refresh read");
        rd(0, 4'd5, 32'd9, "R3 snap refreshed");

        // R3 torn read: second reader refreshes between first reader's accesses
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd4, 32'd3);
        rd(0, 4'd3, 32'hFFFF_FFFF, "R3 reader A low");
        ticks(1);
        rd(0, 4'd3, 32'h0, "R3 reader B low");
        rd(0, 4'd5, 32'd4, "R3 torn high is 2^32 too high");

        // R7 R8 compare reset in mode 0
        wr(4'd7, 32'h0000_8000);
        wr(4'd3, 32'h0);
        wr(4'd4, 32'h0);
        wr(4'd1, 32'd3);
        wr(4'd2, 32'd0);
        wr(4'd0, 32'h0);
        wr(4'd6, 32'h0000_8000);
        ticks(3);
        rd(0, 4'd3, 32'd3, "R7 reaches compare");
        rd(0, 4'd9, 32'h0, "R8 no match yet");
        ticks(1);
        rd(0, 4'd3, 32'h0, "R7 reset after compare");
        rd(0, 4'd9, 32'h1, "R8 match set");
        wr(4'd9, 32'h0);
        rd(0, 4'd9, 32'h1, "R8 zero write keeps flag");
        wr(4'd9, 32'h1);
        rd(0, 4'd9, 32'h0, "R8 flag cleared");

        // R6 R9 free-running mode
        wr(4'd0, 32'hFFFF_FFFF);
        rd(0, 4'd0, 32'h0000_80C0, "R9 ctrl readback");
        ticks(5);
        rd(0, 4'd3, 32'd5, "R6 runs past compare");
        rd(0, 4'd9, 32'h1, "R8 match in free mode");
        wr(4'd0, 32'h0000_8000);
        rd(0, 4'd0, 32'h0000_8000, "R9 field cleared");
        ticks(1);
        rd(0, 4'd3, 32'd6, "R9 field has no effect");

        // R11 unmapped and idle reads
        rd(0, 4'd12, 32'h0, "R11 unmapped");
        rd(0, 4'd15, 32'h0, "R11 unmapped top");
        #1;
        checks++;
        if (rd_wide !== 32'h0) begin
            errors++;
            $display("FAIL R11 idle read got %h exp %h", rd_wide, 32'h0);
        end

        // R10 legacy 32-bit variant
        wr(4'd4, 32'hFFFF_FFFE);
        ticks(3);
        rd(1, 4'd4, 32'h1, "R10 legacy wraps at 32 bits");
        rd(1, 4'd3, 32'h0, "R10 legacy low reads 0");
        rd(1, 4'd5, 32'h0, "R10 legacy snap reads 0");
        rd(1, 4'd2, 32'h0, "R10 legacy cmp_hi reads 0");

        repeat (2) @(posedge clk);
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard left %0d exp 0", sb_q.size());
        end
        summary();
    end
endmodule